// File: doc/BRIEF.md
# Indexed Address Generator with Cycle Penalty

This unit sits beside the instruction sequencer of a small 8-bit processor. In one cycle it forms the 16-bit effective address of an operand from the instruction's operand bytes, the X and Y index registers and an addressing-mode code. It also reports how many extra cycles, from zero to two, the access will cost. Relative branches are handled in the same unit. It computes the branch target from the next-instruction address and a signed offset, and charges the taken and page-crossing penalties.

Indirect modes need a 16-bit pointer that is stored in page zero. The unit presents two byte addresses on a small read port, and the surrounding logic returns the two bytes in the same cycle. A request is accepted when `in_valid` is high. The results appear registered on the next clock edge, together with the page-zero location that held the pointer.

Top module: `idx_addr_gen`

## Requirements
- R1: After synchronous reset, `out_valid`, `eff_addr`, `ptr_addr` and `extra_cyc` are all zero.
- R2: A request with `in_valid` high updates all outputs at the next clock edge, and `out_valid` is high for exactly that cycle. While `in_valid` is low, `out_valid` is low and the outputs hold. The mode codes are: implied 0, immediate 1, zero page 2, zero page X 3, zero page Y 4, absolute 5, absolute X 6, absolute Y 7, pre-indexed indirect 8, post-indexed indirect 9, page-zero indirect 10, relative 11.
- R3: Zero-page modes give `{8'h00, op_lo}`. The X and Y forms add the index modulo 256, so the upper address byte is always zero.
- R4: Absolute mode gives `{op_hi, op_lo}`. The X and Y forms add the index to that base modulo 65536.
- R5: For absolute X, absolute Y and post-indexed indirect reads, `extra_cyc` is 1 when the upper byte of the base differs from the upper byte of the final address, and 0 otherwise.
- R6: When `is_write` is high, no addressing mode other than relative reports an extra cycle.
- R7: Pre-indexed indirect takes the low address byte from page-zero location `(op_lo+X) mod 256` and the high byte from the next location modulo 256. `ptr_addr` reports the first location, and no extra cycle is charged.
- R8: Post-indexed indirect reads the pointer from `op_lo` and `(op_lo+1) mod 256`, adds Y modulo 65536, and reports `op_lo` on `ptr_addr`.
- R9: Page-zero indirect reads the pointer the same way as R8, but without an index and without an extra cycle.
- R10: Relative mode gives `pc_next` plus the sign-extended `op_lo`, modulo 65536, whether or not the branch is taken.
- R11: A branch that is not taken costs 0 extra cycles. A taken branch costs 1 extra cycle, or 2 when the target's upper byte differs from that of `pc_next`.
- R12: Implied mode gives address 0. Immediate mode gives `pc_next - 1`. Neither charges extra cycles, and `ptr_addr` is 0 for every mode other than modes 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte (also the branch offset) |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| is_write | input | 1 | Instruction stores to or modifies memory |
| br_taken | input | 1 | Branch condition holds |
| pc_next | input | 16 | Address of the next instruction |
| zp_rd_addr0 | output | 8 | Page-zero read address, pointer low byte |
| zp_rd_addr1 | output | 8 | Page-zero read address, pointer high byte |
| zp_rd_data0 | input | 8 | Byte at zp_rd_addr0, same cycle |
| zp_rd_data1 | input | 8 | Byte at zp_rd_addr1, same cycle |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address or branch target |
| ptr_addr | output | 8 | Page-zero location of the pointer |
| extra_cyc | output | 2 | Extra cycle count, 0 to 2 |

## Verification
Several properties are checked on every cycle. `out_valid` follows the strobe and the outputs hold while it is idle. Zero-page results stay in page zero. Stores never take a penalty. Untaken branches and the non-indexed modes are free of extra cycles, and the count never reaches 3. The actual arithmetic can only be shown by the bench's scenarios, which compare against an independent model. That arithmetic covers the carry from 0x10FF into 0x1100, pointer wrap from 0xFF to 0x00, backward branches across a page, and pointer bytes fetched from a bench-held page-zero memory.

// File: rtl/iag_pkg.sv
package iag_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int XC_W    = 2;
    localparam int MODE_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPL  = 4'd0,
        AM_IMM   = 4'd1,
        AM_ZP    = 4'd2,
        AM_ZPX   = 4'd3,
        AM_ZPY   = 4'd4,
        AM_ABS   = 4'd5,
        AM_ABSX  = 4'd6,
        AM_ABSY  = 4'd7,
        AM_INDX  = 4'd8,
        AM_INDY  = 4'd9,
        AM_ZPIND = 4'd10,
        AM_REL   = 4'd11
    } amode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] ptr;
        logic [XC_W-1:0]   extra;
    } agen_res_t;

    function automatic logic page_moved(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:BYTE_W] != b[ADDR_W-1:BYTE_W];
    endfunction

    function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
        return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] widen_byte(input logic [BYTE_W-1:0] v);
        return {{(ADDR_W-BYTE_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/iag_zp_unit.sv
module iag_zp_unit
    import iag_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  amode_e          mode,
    input  logic [BW-1:0]   op_lo,
    input  logic [BW-1:0]   idx_x,
    input  logic [BW-1:0]   idx_y,
    output logic [BW-1:0]   zp_eff,
    output logic [BW-1:0]   ptr_loc,
    output logic [BW-1:0]   ptr_loc_nxt
);
    // page-zero operand location, wrapping within the page
    always_comb begin
        unique case (mode)
            AM_ZPX:  zp_eff = op_lo + idx_x;
            AM_ZPY:  zp_eff = op_lo + idx_y;
            default: zp_eff = op_lo;
        endcase
    end

    // pointer location: pre-indexed uses X before the fetch
    always_comb begin
        ptr_loc     = (mode == AM_INDX) ? op_lo + idx_x : op_lo;
        ptr_loc_nxt = ptr_loc + {{(BW-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/iag_idx_add.sv
module iag_idx_add
    import iag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic [AW-1:0]   base,
    input  logic [BW-1:0]   idx,
    input  logic            is_write,
    output logic [AW-1:0]   sum,
    output logic [XC_W-1:0] extra
);
    always_comb begin
        sum   = base + {{(AW-BW){1'b0}}, idx};
        extra = (!is_write && page_moved(base, sum)) ? XC_W'(1) : '0;
    end
endmodule

// File: rtl/iag_branch.sv
module iag_branch
    import iag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic [AW-1:0]   pc_next,
    input  logic [BW-1:0]   offset,
    input  logic            taken,
    output logic [AW-1:0]   target,
    output logic [XC_W-1:0] extra
);
    always_comb begin
        target = pc_next + sext_byte(offset);
        if (!taken)
            extra = '0;
        else if (page_moved(pc_next, target))
            extra = XC_W'(2);
        else
            extra = XC_W'(1);
    end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import iag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      mode,
    input  logic [7:0]      op_lo,
    input  logic [7:0]      op_hi,
    input  logic [7:0]      idx_x,
    input  logic [7:0]      idx_y,
    input  logic            is_write,
    input  logic            br_taken,
    input  logic [15:0]     pc_next,
    output logic [7:0]      zp_rd_addr0,
    output logic [7:0]      zp_rd_addr1,
    input  logic [7:0]      zp_rd_data0,
    input  logic [7:0]      zp_rd_data1,
    output logic            out_valid,
    output logic [15:0]     eff_addr,
    output logic [7:0]      ptr_addr,
    output logic [1:0]      extra_cyc
);
    localparam int LANES = 2;   // lane 0: absolute indexed, lane 1: pointer plus Y

    amode_e            m;
    logic [BW-1:0]     zp_eff, ploc, ploc_nxt;
    logic [AW-1:0]     ptr_word, abs_word;
    logic [AW-1:0]     br_tgt;
    logic [XC_W-1:0]   br_xc;
    logic [AW-1:0]     lane_base [LANES];
    logic [BW-1:0]     lane_idx  [LANES];
    logic [AW-1:0]     lane_sum  [LANES];
    logic [XC_W-1:0]   lane_xc   [LANES];
    agen_res_t         nxt, res_q;
    amode_e            r_mode;
    logic              r_write, r_taken, r_valid;

    assign m        = amode_e'(mode);
    assign abs_word = {op_hi, op_lo};
    assign ptr_word = {zp_rd_data1, zp_rd_data0};

    iag_zp_unit #(.BW(BW)) u_zp (
        .mode        (m),
        .op_lo       (op_lo),
        .idx_x       (idx_x),
        .idx_y       (idx_y),
        .zp_eff      (zp_eff),
        .ptr_loc     (ploc),
        .ptr_loc_nxt (ploc_nxt)
    );

    assign zp_rd_addr0 = ploc;
    assign zp_rd_addr1 = ploc_nxt;

    assign lane_base[0] = abs_word;
    assign lane_idx[0]  = (m == AM_ABSY) ? idx_y : idx_x;
    assign lane_base[1] = ptr_word;
    assign lane_idx[1]  = idx_y;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        iag_idx_add #(.AW(AW), .BW(BW)) u_add (
            .base     (lane_base[g]),
            .idx      (lane_idx[g]),
            .is_write (is_write),
            .sum      (lane_sum[g]),
            .extra    (lane_xc[g])
        );
    end

    iag_branch #(.AW(AW), .BW(BW)) u_br (
        .pc_next (pc_next),
        .offset  (op_lo),
        .taken   (br_taken),
        .target  (br_tgt),
        .extra   (br_xc)
    );

    always_comb begin
        nxt = '0;
        unique case (m)
            AM_IMPL:  nxt.addr = '0;
            AM_IMM:   nxt.addr = pc_next - AW'(1);
            AM_ZP, AM_ZPX, AM_ZPY:
                      nxt.addr = widen_byte(zp_eff);
            AM_ABS:   nxt.addr = abs_word;
            AM_ABSX, AM_ABSY: begin
                nxt.addr  = lane_sum[0];
                nxt.extra = lane_xc[0];
            end
            AM_INDX, AM_ZPIND: begin
                nxt.addr = ptr_word;
                nxt.ptr  = ploc;
            end
            AM_INDY: begin
                nxt.addr  = lane_sum[1];
                nxt.extra = lane_xc[1];
                nxt.ptr   = ploc;
            end
            AM_REL: begin
                nxt.addr  = br_tgt;
                nxt.extra = br_xc;
            end
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            r_valid <= 1'b0;
            r_mode  <= AM_IMPL;
            r_write <= 1'b0;
            r_taken <= 1'b0;
        end else begin
            r_valid <= in_valid;
            if (in_valid) begin
                res_q   <= nxt;
                r_mode  <= m;
                r_write <= is_write;
                r_taken <= br_taken;
            end
        end
    end

    assign out_valid = r_valid;
    assign eff_addr  = res_q.addr;
    assign ptr_addr  = res_q.ptr;
    assign extra_cyc = res_q.extra;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(eff_addr) && $stable(extra_cyc)
                       && $stable(ptr_addr)));

    a_r3_zp_stays_low: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (r_mode == AM_ZP || r_mode == AM_ZPX || r_mode == AM_ZPY))
        |-> eff_addr[15:8] == 8'h00);

    a_r6_store_no_penalty: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_write && r_mode != AM_REL) |-> extra_cyc == 2'd0);

    a_r11_untaken_free: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_mode == AM_REL && !r_taken) |-> extra_cyc == 2'd0);

    a_r11_count_range: assert property (@(posedge clk) disable iff (rst)
        extra_cyc != 2'd3);

    a_r12_plain_modes_free: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (r_mode == AM_IMPL || r_mode == AM_IMM || r_mode == AM_ZP ||
                       r_mode == AM_ZPX || r_mode == AM_ZPY || r_mode == AM_ABS ||
                       r_mode == AM_INDX || r_mode == AM_ZPIND))
        |-> extra_cyc == 2'd0);
endmodule

// File: tb/tb_idx_addr_gen.sv
`timescale 1ns/1ps
module tb_idx_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
    logic        is_write = 1'b0, br_taken = 1'b0;
    logic [15:0] pc_next = '0;
    logic [7:0]  zp_rd_addr0, zp_rd_addr1, zp_rd_data0, zp_rd_data1;
    logic        out_valid;
    logic [15:0] eff_addr;
    logic [7:0]  ptr_addr;
    logic [1:0]  extra_cyc;

    logic [7:0]  zmem [256];
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    assign zp_rd_data0 = zmem[zp_rd_addr0];
    assign zp_rd_data1 = zmem[zp_rd_addr1];

    idx_addr_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
        .is_write(is_write), .br_taken(br_taken), .pc_next(pc_next),
        .zp_rd_addr0(zp_rd_addr0), .zp_rd_addr1(zp_rd_addr1),
        .zp_rd_data0(zp_rd_data0), .zp_rd_data1(zp_rd_data1),
        .out_valid(out_valid), .eff_addr(eff_addr), .ptr_addr(ptr_addr),
        .extra_cyc(extra_cyc)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input int md);
        case (md)
            0, 1:     return "R12";
            2, 3, 4:  return "R3";
            5, 6, 7:  return "R4";
            8:        return "R7";
            9:        return "R8";
            10:       return "R9";
            default:  return "R10";
        endcase
    endfunction

    // independent model: {addr, ptr, extra}
    function automatic logic [25:0] model(input int md, input logic [7:0] lo, hi, x, y,
                                          input logic wr, tk, input logic [15:0] pc);
        int a = 0, p = 0, xc = 0, base = 0, loc = 0;
        case (md)
            0: a = 0;
            1: a = (pc + 65535) % 65536;
            2: a = lo;
            3: a = (lo + x) % 256;
            4: a = (lo + y) % 256;
            5: a = hi * 256 + lo;
            6, 7: begin
                base = hi * 256 + lo;
                a = (base + ((md == 6) ? x : y)) % 65536;
                if (!wr && (a / 256) != (base / 256)) xc = 1;
            end
            8: begin
                loc = (lo + x) % 256;
                a = zmem[(loc + 1) % 256] * 256 + zmem[loc];
                p = loc;
            end
            9, 10: begin
                base = zmem[(lo + 1) % 256] * 256 + zmem[lo];
                p = lo;
                a = (md == 9) ? (base + y) % 65536 : base;
                if (md == 9 && !wr && (a / 256) != (base / 256)) xc = 1;
            end
            default: begin
                a = (pc + ((lo >= 128) ? lo - 256 : lo) + 65536) % 65536;
                if (tk) xc = ((a / 256) != (pc / 256)) ? 2 : 1;
            end
        endcase
        return {a[15:0], p[7:0], xc[1:0]};
    endfunction

    task automatic run(input int md, input logic [7:0] lo, hi, x, y,
                       input logic wr, tk, input logic [15:0] pc, input bit hold_chk);
        logic [25:0] e;
        @(negedge clk);
        mode = md[3:0]; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
        is_write = wr; br_taken = tk; pc_next = pc; in_valid = 1'b1;
        e = model(md, lo, hi, x, y, wr, tk, pc);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 out_valid", int'(out_valid), 1);
        check({tag_of(md), " addr"}, int'(eff_addr), int'(e[25:10]));
        check({tag_of(md), " ptr"}, int'(ptr_addr), int'(e[9:2]));
        if (md == 11)     check("R11 extra", int'(extra_cyc), int'(e[1:0]));
        else if (wr)      check("R6 extra", int'(extra_cyc), int'(e[1:0]));
        else if (md == 6 || md == 7 || md == 9)
                          check("R5 extra", int'(extra_cyc), int'(e[1:0]));
        else              check({tag_of(md), " extra"}, int'(extra_cyc), int'(e[1:0]));
        if (hold_chk) begin
            mode = 4'd5; op_lo = ~lo; op_hi = ~hi; pc_next = ~pc;
            @(negedge clk);
            check("R2 idle valid", int'(out_valid), 0);
            check("R2 idle hold", int'(eff_addr), int'(e[25:10]));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom());
        zmem[8'hFF] = 8'hFF; zmem[8'h00] = 8'h20;   // pointer 0x20FF across wrap
        zmem[8'h40] = 8'h80; zmem[8'h41] = 8'h12;   // pointer 0x1280
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 addr", int'(eff_addr), 0);
        check("R1 ptr", int'(ptr_addr), 0);
        check("R1 extra", int'(extra_cyc), 0);
        rst = 1'b0;
        // R5 / R6 page cross 0x10FF + 1
        run(6, 8'hFF, 8'h10, 8'h01, 8'h00, 1'b0, 1'b0, 16'h0, 1'b1);
        run(6, 8'hFF, 8'h10, 8'h01, 8'h00, 1'b1, 1'b0, 16'h0, 1'b0);
        run(7, 8'h00, 8'h10, 8'h00, 8'hFF, 1'b0, 1'b0, 16'h0, 1'b0);
        run(7, 8'hFF, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b0, 16'h0, 1'b0);
        // R3 page-zero wrap
        run(3, 8'hFF, 8'hAA, 8'h02, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0);
        run(4, 8'h80, 8'h00, 8'h00, 8'h90, 1'b0, 1'b0, 16'h0, 1'b0);
        // R7 pointer straddling 0xFF/0x00
        run(8, 8'hFE, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0);
        // R8 pointer 0x20FF + 1 crosses; R9 no index
        run(9, 8'hFF, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 16'h0, 1'b1);
        run(9, 8'h40, 8'h00, 8'h00, 8'h10, 1'b0, 1'b0, 16'h0, 1'b0);
        run(9, 8'hFF, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 16'h0, 1'b0);
        run(10, 8'h40, 8'h00, 8'h00, 8'h33, 1'b0, 1'b0, 16'h0, 1'b0);
        // R10 / R11 branches
        run(11, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h1000, 1'b0);
        run(11, 8'h80, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h1000, 1'b0);
        run(11, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h10F0, 1'b0);
        run(11, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h10F0, 1'b0);
        run(11, 8'hFE, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
        // R12 implied / immediate
        run(0, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 1'b0, 16'h5555, 1'b0);
        run(1, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            run(int'($urandom_range(0, 11)), 8'($urandom()), 8'($urandom()),
                8'($urandom()), 8'($urandom()), 1'($urandom()), 1'($urandom()),
                16'($urandom()), (i % 16) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule